// File: doc/BRIEF.md
# Rate-Limited Serial Sensor Poller

This block fetches readings from a slow hardware-monitor device on three lines: an active-low select, a serial clock and a data line that the device drives. One fetch drops the select and holds the clock low for a long setup wait. It then runs 32 clock periods with long low and high phases, taking one data bit on each rising edge, and raises the select again. The 32-bit word that comes back holds a check byte of 0x55, an 8-bit fan reading in steps of 100 RPM and a 16-bit temperature in steps of 0.1 degree.

The client pulses a request and receives a one-cycle valid with the fan and temperature fields. The device is slow, so a refresh limiter allows a new fetch only after a set interval has passed since the last good one. A request inside that window is answered at once from the held copy. A word whose top byte is not the check value leaves the held copy unchanged, raises a one-cycle error and does not restart the window, so the next request fetches again. All delays are parameters in system-clock cycles. The defaults suit a 100 MHz clock: 100 ms setup, 100 us phases and a 1 s refresh interval.

Top module: `sensor_poller`

## Requirements
- R1: After reset, cs_n_o is 1, sclk_o is 0, and busy_o, valid_o, err_o, fan_o and temp_o are all 0.
- R2: A fetch holds cs_n_o at 0 for exactly 32 rising edges of sclk_o. sclk_o is 0 whenever cs_n_o is 1.
- R3: The first rising edge of sclk_o comes exactly SETUP_CYC + PHASE_CYC cycles after cs_n_o falls. The clock is low for all of that time.
- R4: After the first rising edge, every high and low phase of sclk_o lasts exactly PHASE_CYC cycles. The last falling edge happens in the same cycle that cs_n_o rises.
- R5: sdata_i is sampled at each rising edge of sclk_o, most significant bit first. Bits 31:24 are the check byte, 23:16 the fan reading and 15:0 the temperature. If the check byte is 0x55, fan_o and temp_o take the new fields and valid_o pulses for one cycle, all in the cycle that cs_n_o rises.
- R6: A request that arrives within REFRESH_CYC cycles after a good fetch starts no fetch. valid_o pulses in the next cycle with the held fan_o and temp_o.
- R7: If the check byte is not 0x55, err_o pulses for one cycle, valid_o stays 0, and fan_o and temp_o keep their values.
- R8: A failed check does not restart the refresh window. A request right after a failure starts a new fetch.
- R9: busy_o is 1 exactly while cs_n_o is 0. A request seen during a fetch is ignored, so the fetch gives exactly one valid_o pulse.
- R10: The first request after reset starts a fetch. So does any request made more than REFRESH_CYC cycles after the last good fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Reading request, sampled while idle |
| cs_n_o | output | 1 | Device select, active low |
| sclk_o | output | 1 | Serial clock to the device |
| sdata_i | input | 1 | Serial data from the device |
| busy_o | output | 1 | Fetch in progress |
| valid_o | output | 1 | One-cycle pulse: fan_o/temp_o are presented |
| err_o | output | 1 | One-cycle pulse: received check byte was wrong |
| fan_o | output | 8 | Fan reading, units of 100 RPM |
| temp_o | output | 16 | Temperature reading, units of 0.1 degree |

## Verification
Two things can fall in the same cycle: a client request, and the last clock phase of a fetch, when the select rises and the held values update. The bench keeps the request high from before the fetch starts until the valid pulse appears, so the request is present in the final cycle of the transfer. It then expects exactly one response on the scoreboard and no second falling edge of the select. A held-copy request is also made straight after a fetch completes, to show that the fresh window and the cached answer come right after one another without overlapping.

// File: rtl/sp_pkg.sv
package sp_pkg;
    localparam int WORD_W = 32;
    localparam int MARK_W = 8;
    localparam int FAN_W  = 8;
    localparam int TEMP_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH
    } poll_st_e;
endpackage

// File: rtl/sp_word_chk.sv
module sp_word_chk
    import sp_pkg::*;
#(
    parameter logic [MARK_W-1:0] MARKER = 8'h55
) (
    input  logic [WORD_W-1:0] word_i,
    output logic              ok_o,
    output logic [FAN_W-1:0]  fan_o,
    output logic [TEMP_W-1:0] temp_o
);
    localparam int TEMP_LO = 0;
    localparam int FAN_LO  = TEMP_LO + TEMP_W;
    localparam int MARK_LO = FAN_LO + FAN_W;

    always_comb begin
        ok_o   = (word_i[MARK_LO +: MARK_W] == MARKER);
        fan_o  = word_i[FAN_LO +: FAN_W];
        temp_o = word_i[TEMP_LO +: TEMP_W];
    end
endmodule

// File: rtl/sp_limiter.sv
module sp_limiter #(
    parameter int unsigned REFRESH_CYC = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic ready_o
);
    localparam int RW = $clog2(REFRESH_CYC + 1);

    logic [RW-1:0] rem_d, rem_q;

    always_comb begin
        rem_d = rem_q;
        if (restart_i)
            rem_d = RW'(REFRESH_CYC);
        else if (rem_q != '0)
            rem_d = rem_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= rem_d;
    end

    assign ready_o = (rem_q == '0);

    // R6
    window_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !ready_o);
endmodule

// File: rtl/sensor_poller.sv
module sensor_poller
    import sp_pkg::*;
#(
    parameter int unsigned       SETUP_CYC   = 10_000_000,
    parameter int unsigned       PHASE_CYC   = 10_000,
    parameter int unsigned       REFRESH_CYC = 100_000_000,
    parameter logic [MARK_W-1:0] MARKER      = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    output logic              cs_n_o,
    output logic              sclk_o,
    input  logic              sdata_i,
    output logic              busy_o,
    output logic              valid_o,
    output logic              err_o,
    output logic [FAN_W-1:0]  fan_o,
    output logic [TEMP_W-1:0] temp_o
);
    localparam int unsigned CNT_MAX = (SETUP_CYC > PHASE_CYC) ? SETUP_CYC : PHASE_CYC;
    localparam int CW = $clog2(CNT_MAX + 1);
    localparam int BW = $clog2(WORD_W);

    typedef struct packed {
        poll_st_e           st;
        logic [CW-1:0]      cnt;
        logic [BW-1:0]      bits;
        logic [WORD_W-1:0]  sh;
        logic               cs_n;
        logic               sclk;
        logic               valid;
        logic               err;
        logic [FAN_W-1:0]   fan;
        logic [TEMP_W-1:0]  temp;
    } poll_regs_t;

    poll_regs_t r_d, r_q;

    logic              lim_ready, lim_restart;
    logic              word_ok;
    logic [FAN_W-1:0]  word_fan;
    logic [TEMP_W-1:0] word_temp;

    sp_limiter #(.REFRESH_CYC(REFRESH_CYC)) u_lim (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (lim_restart),
        .ready_o   (lim_ready)
    );

    sp_word_chk #(.MARKER(MARKER)) u_chk (
        .word_i (r_q.sh),
        .ok_o   (word_ok),
        .fan_o  (word_fan),
        .temp_o (word_temp)
    );

    always_comb begin
        r_d         = r_q;
        r_d.valid   = 1'b0;
        r_d.err     = 1'b0;
        lim_restart = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    if (lim_ready) begin
                        r_d.st   = ST_SETUP;
                        r_d.cnt  = '0;
                        r_d.bits = '0;
                        r_d.cs_n = 1'b0;
                    end else begin
                        r_d.valid = 1'b1;
                    end
                end
            end
            ST_SETUP: begin
                if (r_q.cnt == CW'(SETUP_CYC - 1)) begin
                    r_d.st  = ST_LOW;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_LOW: begin
                if (r_q.cnt == CW'(PHASE_CYC - 1)) begin
                    r_d.st   = ST_HIGH;
                    r_d.cnt  = '0;
                    r_d.sclk = 1'b1;
                    r_d.sh   = {r_q.sh[WORD_W-2:0], sdata_i};
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_HIGH: begin
                if (r_q.cnt == CW'(PHASE_CYC - 1)) begin
                    r_d.cnt  = '0;
                    r_d.sclk = 1'b0;
                    if (r_q.bits == BW'(WORD_W - 1)) begin
                        r_d.st   = ST_IDLE;
                        r_d.cs_n = 1'b1;
                        if (word_ok) begin
                            r_d.fan     = word_fan;
                            r_d.temp    = word_temp;
                            r_d.valid   = 1'b1;
                            lim_restart = 1'b1;
                        end else begin
                            r_d.err = 1'b1;
                        end
                    end else begin
                        r_d.bits = r_q.bits + 1'b1;
                        r_d.st   = ST_LOW;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.cs_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_n_o  = r_q.cs_n;
    assign sclk_o  = r_q.sclk;
    assign busy_o  = ~r_q.cs_n;
    assign valid_o = r_q.valid;
    assign err_o   = r_q.err;
    assign fan_o   = r_q.fan;
    assign temp_o  = r_q.temp;

    // Phase-width observer: cycles since the last clock change or select fall.
    logic          sclk_prev_q, cs_prev_q;
    logic [CW:0]   gap_q;
    logic          clk_evt, sel_evt;

    assign clk_evt = (r_q.sclk != sclk_prev_q);
    assign sel_evt = cs_prev_q && !r_q.cs_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
            cs_prev_q   <= 1'b1;
            gap_q       <= '0;
        end else begin
            sclk_prev_q <= r_q.sclk;
            cs_prev_q   <= r_q.cs_n;
            if (clk_evt || sel_evt)
                gap_q <= (CW+1)'(1);
            else if (gap_q != '1)
                gap_q <= gap_q + 1'b1;
        end
    end

    // R2
    idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cs_n |-> !r_q.sclk);

    // R2
    toggle_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.sclk) |-> !$past(r_q.cs_n));

    // R4
    phase_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_evt |-> (gap_q >= (CW+1)'(PHASE_CYC)));

    // R6
    start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.cs_n) |-> $past(lim_ready));

    // R7
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.valid && r_q.err));

    // R7
    cache_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({r_q.fan, r_q.temp}) |-> r_q.valid);

    // R9
    busy_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == !cs_n_o);
endmodule

// File: tb/sim_sensor_poller.sv
`timescale 1ns/1ps
module sim_sensor_poller;
    localparam int S  = 20;
    localparam int P  = 4;
    localparam int RF = 2000;

    logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, sdata = 1'b0;
    logic cs_n, sclk, busy, valid, err;
    logic [7:0]  fan;
    logic [15:0] temp;

    always #5 clk = ~clk;

    sensor_poller #(.SETUP_CYC(S), .PHASE_CYC(P), .REFRESH_CYC(RF)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .cs_n_o(cs_n), .sclk_o(sclk),
        .sdata_i(sdata), .busy_o(busy), .valid_o(valid), .err_o(err),
        .fan_o(fan), .temp_o(temp)
    );

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Device model: first bit on select fall, next bit on each clock fall.
    logic [31:0] dev_word = 32'h0;
    int idx = 0;
    always @(negedge cs_n) begin
        idx   = 31;
        sdata = dev_word[31];
    end
    always @(negedge sclk) begin
        if (!cs_n && idx > 0) begin
            idx   = idx - 1;
            sdata = dev_word[idx];
        end
    end

    // Scoreboard
    typedef struct {
        bit          is_err;
        logic [7:0]  fan;
        logic [15:0] temp;
    } exp_t;
    exp_t exq[$];
    int   resp = 0;
    logic [7:0]  m_fan  = 8'h0;
    logic [15:0] m_temp = 16'h0;

    always @(negedge clk) begin
        exp_t e;
        if (rst_n && (valid || err)) begin
            resp++;
            chk(!(valid && err), "R7 valid and err together", {valid, err}, 2'b00);
            if (exq.size() == 0) begin
                chk(1'b0, "R9 unexpected response", {valid, err}, 0);
            end else begin
                e = exq.pop_front();
                chk(err == e.is_err, "R7 response kind (err)", err, e.is_err);
                if (!e.is_err) begin
                    chk(fan == e.fan, "R5 fan field", fan, e.fan);
                    chk(temp == e.temp, "R5 temp field", temp, e.temp);
                    chk(cs_n == 1'b1, "R5 valid with select released", cs_n, 1);
                end
            end
        end
    end

    // Timing monitor
    int cyc = 0, t_last = 0, rises = 0, n_fall = 0;
    bit first = 0, bad3 = 0, bad4 = 0, bad2 = 0;
    logic cs_p = 1'b1, sclk_p = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (cs_p && !cs_n) begin
                n_fall++;
                t_last = cyc; rises = 0; first = 1;
                bad2 = 0; bad3 = 0; bad4 = 0;
            end
            if (sclk != sclk_p) begin
                if (first) begin
                    if (cyc - t_last != S + P) bad3 = 1;
                    first = 0;
                end else if (cyc - t_last != P) begin
                    bad4 = 1;
                end
                if (sclk) rises++;
                t_last = cyc;
            end
            if (sclk && cs_n) bad2 = 1;
            if (!cs_p && cs_n) begin
                chk(rises == 32, "R2 rising edges per fetch", rises, 32);
                chk(!bad2, "R2 clock low while deselected", bad2, 0);
                chk(!bad3, "R3 setup to first rise", bad3, 0);
                chk(!bad4, "R4 phase widths", bad4, 0);
            end
            cs_p   = cs_n;
            sclk_p = sclk;
        end
    end

    task automatic wait_resp(input int target);
        while (resp < target) @(negedge clk);
    endtask

    task automatic fetch(input logic [31:0] w, input bit good, input string tag);
        exp_t e;
        int f0, r0;
        dev_word = w;
        e.is_err = !good;
        e.fan    = good ? w[23:16] : m_fan;
        e.temp   = good ? w[15:0]  : m_temp;
        exq.push_back(e);
        f0 = n_fall; r0 = resp;
        @(negedge clk) req = 1'b1;
        @(negedge clk) req = 1'b0;
        chk(busy == 1'b1, {tag, " busy during fetch"}, busy, 1);
        wait_resp(r0 + 1);
        @(negedge clk);
        chk(n_fall == f0 + 1, {tag, " one fetch started"}, n_fall - f0, 1);
        if (good) begin
            m_fan = w[23:16]; m_temp = w[15:0];
        end
        chk(fan == m_fan, {tag, " fan after fetch"}, fan, m_fan);
        chk(temp == m_temp, {tag, " temp after fetch"}, temp, m_temp);
    endtask

    task automatic cached(input string tag);
        exp_t e;
        int f0;
        e.is_err = 0; e.fan = m_fan; e.temp = m_temp;
        exq.push_back(e);
        f0 = n_fall;
        dev_word = 32'h55FF_FFFF;
        @(negedge clk) req = 1'b1;
        @(negedge clk) req = 1'b0;
        chk(valid == 1'b1, {tag, " cached valid next cycle"}, valid, 1);
        chk(busy == 1'b0, {tag, " no busy on cached read"}, busy, 0);
        repeat (S + 4) @(negedge clk);
        chk(n_fall == f0, {tag, " no fetch started"}, n_fall - f0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int r0, f0;
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R1 reset cs_n", cs_n, 1);
        chk(sclk == 1'b0, "R1 reset sclk", sclk, 0);
        chk({busy, valid, err} == 3'b000, "R1 reset flags", {busy, valid, err}, 0);
        chk({fan, temp} == 24'h0, "R1 reset data", {fan, temp}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        fetch(32'h552A_0123, 1'b1, "R10 first");
        cached("R6 immediate");
        repeat (1000) @(negedge clk);
        cached("R6 mid-window");

        repeat (RF + 10) @(negedge clk);
        fetch(32'h5507_FEDC, 1'b1, "R10 after window");

        repeat (RF + 10) @(negedge clk);
        fetch(32'h5411_2222, 1'b0, "R7 bad marker");
        fetch(32'h5563_0400, 1'b1, "R8 retry after failure");
        cached("R6 after retry");

        // R9: request held across the whole fetch, including its last cycle
        repeat (RF + 10) @(negedge clk);
        begin
            exp_t e;
            dev_word = 32'h553C_8001;
            e.is_err = 0; e.fan = 8'h3C; e.temp = 16'h8001;
            exq.push_back(e);
            r0 = resp; f0 = n_fall;
            @(negedge clk) req = 1'b1;
            while (!valid) @(negedge clk);
            req = 1'b0;
            m_fan = 8'h3C; m_temp = 16'h8001;
            repeat (S + 10) @(negedge clk);
            chk(resp == r0 + 1, "R9 single response while held", resp - r0, 1);
            chk(n_fall == f0 + 1, "R9 single fetch while held", n_fall - f0, 1);
        end

        chk(exq.size() == 0, "R9 scoreboard drained", exq.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule